// File: doc/BRIEF.md
# Paged Address Extension Memory Mapper

This block sits between a CPU with a 16-bit address bus and the memory system. It cuts the 64 kB logical space into sixteen 4 kB pages. Each page owns a 20-bit descriptor register holding three fields: a replacement page frame that widens the address to 20 bits (1 MB), a set of eight chip-enable lines that pre-decode the target device, and a base wait-state count. One shallow lookup, indexed by the top four address bits, produces all three results. The translated address and the chip enables therefore appear with only a 16-to-1 multiplexer added to the address path.

A memory access is a valid/ready handshake. The CPU raises `req_valid` with a stable `req_addr` and keeps both until it sees `req_ready` high at a clock edge. That edge completes the access. The mapper applies back-pressure by holding `req_ready` low for the page's programmed wait count. If `req_valid` stays high after the completing edge, a new access starts in the next cycle. When a page's wait count is nonzero, the first cycle of the access captures the descriptor. A descriptor write that lands during an access therefore cannot change that access. Chip-enable bit 0 marks internal memory and is also brought out on its own pin. This lets the internal/external read-data multiplexer be steered by one signal.

Descriptors are written through a plain port: a write strobe, a page index and 20 bits of data.

Top module: `pgmap_mmu`

## Requirements
- R1: For an access to logical address A, `phys_addr` equals the selected page's 8-bit frame field followed by A[11:0]. The page is chosen by A[15:12].
- R2: Descriptor data is laid out as frame = bits [7:0], chip enables = bits [15:8], wait count = bits [19:16]. A write with `cfg_we` high updates the page given by `cfg_page` at the next rising clock edge.
- R3: While `req_valid` is high, `chip_en` equals the chip-enable field of the accessed page. While `req_valid` is low, `chip_en` is all zeros.
- R4: `int_sel` always equals `chip_en[0]`, the internal-memory enable.
- R5: An access to a page whose wait count is 0 sees `req_ready` high in its first cycle.
- R6: An access to a page with wait count N > 0 sees `req_ready` low for exactly N cycles and then high for one cycle.
- R7: A descriptor write in the first cycle of a stalled access leaves that access's frame, chip enables and stall length unchanged. The next access to that page uses the new descriptor.
- R8: After reset, page p has frame = p, chip enables = 8'h01 and wait count = 0.
- R9: `req_ready` is low whenever `req_valid` is low.
- R10: If `req_valid` stays high after a completing edge, a new access starts in the next cycle with a fresh lookup and its own stall length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held until accepted |
| req_addr | input | 16 | Logical CPU address |
| req_ready | output | 1 | Access completes at an edge where this and req_valid are high |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_page | input | 4 | Page whose descriptor is written |
| cfg_data | input | 20 | Descriptor value: wait[19:16], enables[15:8], frame[7:0] |
| phys_addr | output | 20 | Translated physical address |
| chip_en | output | 8 | Chip-enable lines of the accessed page, zero when idle |
| int_sel | output | 1 | Internal-memory select, steers the read-data multiplexer |

## Verification
The bench builds the mapper with its default parameters: a 16-bit address, four page-select bits, an 8-bit frame and a 4-bit wait field. With these values, all sixteen reset descriptors can be walked back to back. The largest stall of 15 cycles, which fills the wait field, is also within reach. The same four-bit page index is shared by the write port and the address, so a write can be aimed at the page of an access already stalled in flight.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  // Default geometry of the mapper
  localparam int unsigned PG_ADDR_W    = 16;
  localparam int unsigned PG_SEL_W     = 4;
  localparam int unsigned PG_FRAME_W   = 8;
  localparam int unsigned PG_CE_W      = 8;
  localparam int unsigned PG_WAIT_W    = 4;
  localparam int unsigned PG_INT_CE    = 0;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_STALL = 1'b1
  } stall_state_e;
endpackage

// File: rtl/pgmap_regfile.sv
module pgmap_regfile #(
  parameter int unsigned SEL_W   = pgmap_pkg::PG_SEL_W,
  parameter int unsigned FRAME_W = pgmap_pkg::PG_FRAME_W,
  parameter int unsigned CE_W    = pgmap_pkg::PG_CE_W,
  parameter int unsigned WAIT_W  = pgmap_pkg::PG_WAIT_W,
  parameter int unsigned INT_CE  = pgmap_pkg::PG_INT_CE,
  localparam int unsigned PAGES  = 1 << SEL_W,
  localparam int unsigned DESC_W = WAIT_W + CE_W + FRAME_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_page,
  input  logic [DESC_W-1:0]            wr_data,
  output logic [PAGES-1:0][DESC_W-1:0] desc_q
);
  localparam logic [CE_W-1:0] CE_RST = CE_W'(1) << INT_CE;

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    localparam logic [DESC_W-1:0] RST_VAL = {{WAIT_W{1'b0}}, CE_RST, FRAME_W'(g)};
    logic [DESC_W-1:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else if (wr_en && (wr_page == SEL_W'(g))) begin
        q <= wr_data;
      end
    end

    assign desc_q[g] = q;
  end
endmodule

// File: rtl/pgmap_lookup.sv
module pgmap_lookup #(
  parameter int unsigned SEL_W   = pgmap_pkg::PG_SEL_W,
  parameter int unsigned FRAME_W = pgmap_pkg::PG_FRAME_W,
  parameter int unsigned CE_W    = pgmap_pkg::PG_CE_W,
  parameter int unsigned WAIT_W  = pgmap_pkg::PG_WAIT_W,
  localparam int unsigned PAGES  = 1 << SEL_W,
  localparam int unsigned DESC_W = WAIT_W + CE_W + FRAME_W
) (
  input  logic [PAGES-1:0][DESC_W-1:0] desc_q,
  input  logic [SEL_W-1:0]             page,
  output logic [FRAME_W-1:0]           frame,
  output logic [CE_W-1:0]              ce,
  output logic [WAIT_W-1:0]            wait_cnt
);
  logic [DESC_W-1:0] sel;

  // Single mux level indexed by the page number
  always_comb begin
    sel      = desc_q[page];
    frame    = sel[FRAME_W-1:0];
    ce       = sel[FRAME_W +: CE_W];
    wait_cnt = sel[FRAME_W+CE_W +: WAIT_W];
  end
endmodule

// File: rtl/pgmap_waitgen.sv
module pgmap_waitgen #(
  parameter int unsigned FRAME_W = pgmap_pkg::PG_FRAME_W,
  parameter int unsigned CE_W    = pgmap_pkg::PG_CE_W,
  parameter int unsigned WAIT_W  = pgmap_pkg::PG_WAIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [FRAME_W-1:0] live_frame,
  input  logic [CE_W-1:0]    live_ce,
  input  logic [WAIT_W-1:0]  live_wait,
  output logic               ready,
  output logic [FRAME_W-1:0] use_frame,
  output logic [CE_W-1:0]    use_ce
);
  import pgmap_pkg::*;

  stall_state_e       state_q;
  logic [WAIT_W-1:0]  cnt_q;
  logic [FRAME_W-1:0] snap_frame_q;
  logic [CE_W-1:0]    snap_ce_q;

  always_comb begin
    if (state_q == ST_IDLE) begin
      use_frame = live_frame;
      use_ce    = live_ce;
      ready     = req_valid && (live_wait == '0);
    end else begin
      use_frame = snap_frame_q;
      use_ce    = snap_ce_q;
      ready     = req_valid && (cnt_q == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      snap_frame_q <= '0;
      snap_ce_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid && (live_wait != '0)) begin
            state_q      <= ST_STALL;
            cnt_q        <= live_wait - 1'b1;
            snap_frame_q <= live_frame;
            snap_ce_q    <= live_ce;
          end
        end
        default: begin
          if (!req_valid || (cnt_q == '0)) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pgmap_mmu.sv
module pgmap_mmu #(
  parameter int unsigned ADDR_W  = pgmap_pkg::PG_ADDR_W,
  parameter int unsigned SEL_W   = pgmap_pkg::PG_SEL_W,
  parameter int unsigned FRAME_W = pgmap_pkg::PG_FRAME_W,
  parameter int unsigned CE_W    = pgmap_pkg::PG_CE_W,
  parameter int unsigned WAIT_W  = pgmap_pkg::PG_WAIT_W,
  parameter int unsigned INT_CE  = pgmap_pkg::PG_INT_CE,
  localparam int unsigned OFFS_W = ADDR_W - SEL_W,
  localparam int unsigned PHYS_W = FRAME_W + OFFS_W,
  localparam int unsigned PAGES  = 1 << SEL_W,
  localparam int unsigned DESC_W = WAIT_W + CE_W + FRAME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_page,
  input  logic [DESC_W-1:0] cfg_data,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [CE_W-1:0]   chip_en,
  output logic              int_sel
);
  logic [PAGES-1:0][DESC_W-1:0] desc_q;
  logic [SEL_W-1:0]   page;
  logic [OFFS_W-1:0]  offset;
  logic [FRAME_W-1:0] live_frame, use_frame;
  logic [CE_W-1:0]    live_ce, use_ce;
  logic [WAIT_W-1:0]  live_wait;

  assign page   = req_addr[ADDR_W-1 -: SEL_W];
  assign offset = req_addr[OFFS_W-1:0];

  pgmap_regfile #(
    .SEL_W(SEL_W), .FRAME_W(FRAME_W), .CE_W(CE_W),
    .WAIT_W(WAIT_W), .INT_CE(INT_CE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_page(cfg_page),
    .wr_data(cfg_data), .desc_q(desc_q)
  );

  pgmap_lookup #(
    .SEL_W(SEL_W), .FRAME_W(FRAME_W), .CE_W(CE_W), .WAIT_W(WAIT_W)
  ) u_lookup (
    .desc_q(desc_q), .page(page), .frame(live_frame),
    .ce(live_ce), .wait_cnt(live_wait)
  );

  pgmap_waitgen #(
    .FRAME_W(FRAME_W), .CE_W(CE_W), .WAIT_W(WAIT_W)
  ) u_wait (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .live_frame(live_frame), .live_ce(live_ce), .live_wait(live_wait),
    .ready(req_ready), .use_frame(use_frame), .use_ce(use_ce)
  );

  assign phys_addr = {use_frame, offset};
  assign chip_en   = req_valid ? use_ce : '0;
  assign int_sel   = chip_en[INT_CE];
endmodule

// File: rtl/pgmap_mmu_chk.sv
module pgmap_mmu_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned PHYS_W  = 20,
  parameter int unsigned CE_W    = 8,
  parameter int unsigned WAIT_W  = 4,
  parameter int unsigned INT_CE  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic [PHYS_W-1:0] phys_addr,
  input logic [CE_W-1:0]   chip_en,
  input logic              int_sel
);
  localparam logic [WAIT_W:0] MAX_STALL = {1'b0, {WAIT_W{1'b1}}};

  logic [WAIT_W:0] stall_run;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_run <= '0;
    else if (req_valid && !req_ready) stall_run <= stall_run + 1'b1;
    else stall_run <= '0;
  end

  // R3: no chip enable without a request
  p_ce_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (chip_en == '0));

  // R4: internal select tracks the internal-memory enable
  p_int_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel == chip_en[INT_CE]);

  // R9: no acceptance without a request
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_ready);

  // R6: a stall never exceeds the widest wait count
  p_stall_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_run <= MAX_STALL);

  // R7: a stalled access keeps its translation
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) ##1 (req_valid && $stable(req_addr))
      |-> ($stable(chip_en) && $stable(phys_addr)));
endmodule

bind pgmap_mmu pgmap_mmu_chk #(
  .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .CE_W(CE_W),
  .WAIT_W(WAIT_W), .INT_CE(INT_CE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_ready(req_ready), .phys_addr(phys_addr), .chip_en(chip_en),
  .int_sel(int_sel)
);

// File: tb/test_pgmap_mmu.sv
`timescale 1ns/1ps
module test_pgmap_mmu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_page = '0;
  logic [19:0] cfg_data = '0;
  logic [19:0] phys_addr;
  logic [7:0]  chip_en;
  logic        int_sel;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pgmap_mmu i_pgmap_mmu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .cfg_we(cfg_we), .cfg_page(cfg_page),
    .cfg_data(cfg_data), .phys_addr(phys_addr), .chip_en(chip_en),
    .int_sel(int_sel)
  );

  // {page, descriptor}: descriptor = wait[19:16], enables[15:8], frame[7:0]
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {4'h0, 20'h0_01_A5},
    {4'h3, 20'h3_02_13},
    {4'h7, 20'h1_80_FF},
    {4'hF, 20'hF_41_00},
    {4'h9, 20'h2_00_09},
    {4'hA, 20'h0_FE_5C}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge
  task automatic wr(input logic [3:0] pg, input logic [19:0] d);
    cfg_we = 1'b1; cfg_page = pg; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One access; req_valid is left high on return (falling edge after completion)
  task automatic access(input logic [15:0] a, input bit we, input logic [3:0] wp,
                        input logic [19:0] wd, input logic [19:0] ep,
                        input logic [7:0] ec, input int ew, input string tag);
    int lows;
    req_valid = 1'b1; req_addr = a;
    cfg_we = we; cfg_page = wp; cfg_data = wd;
    #1;
    chk(32'(phys_addr), 32'(ep), tag, "phys first cycle");
    chk(32'(chip_en), 32'(ec), tag, "chip_en first cycle");
    chk(32'(int_sel), 32'(ec[0]), tag, "int_sel (R4)");
    lows = 0;
    while (!req_ready && lows < 40) begin
      lows++;
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
    end
    chk(32'(phys_addr), 32'(ep), tag, "phys ready cycle");
    chk(32'(chip_en), 32'(ec), tag, "chip_en ready cycle");
    chk(32'(lows), 32'(ew), tag, "wait cycles");
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  logic [3:0]  pg;
  logic [19:0] dd;
  logic [15:0] aa;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R9 / R3: idle after reset
    chk(32'(req_ready), 32'd0, "R9", "ready idle");
    chk(32'(chip_en), 32'd0, "R3", "chip_en idle");
    @(negedge clk);

    // R8: identity map after reset, walked back to back (R10 at zero wait)
    for (int p = 0; p < 16; p++) begin
      aa = {4'(p), 12'hABC};
      access(aa, 1'b0, 4'h0, 20'h0, {8'(p), 12'hABC}, 8'h01, 0, "R8");
    end
    req_valid = 1'b0;
    @(negedge clk);

    // Table walk: R1 R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      pg = VEC[i][23:20];
      dd = VEC[i][19:0];
      wr(pg, dd);
      aa = {pg, 12'h5A3 ^ 12'(i * 273)};
      access(aa, 1'b0, 4'h0, 20'h0, {dd[7:0], aa[11:0]}, dd[15:8],
             int'(dd[19:16]), "R1 R2 R3 R5 R6");
      req_valid = 1'b0;
      #1;
      chk(32'(chip_en), 32'd0, "R3", "chip_en after drop");
      chk(32'(req_ready), 32'd0, "R9", "ready after drop");
      @(negedge clk);
    end

    // R10: maximum stall immediately followed by another stalled access
    access(16'hF010, 1'b0, 4'h0, 20'h0, 20'h00010, 8'h41, 15, "R10 first");
    access(16'h3FFF, 1'b0, 4'h0, 20'h0, 20'h13FFF, 8'h02, 3, "R10 second");
    req_valid = 1'b0;
    @(negedge clk);

    // R7: rewrite the page in the first cycle of its own stalled access
    wr(4'h5, 20'h4_10_33);
    access(16'h5123, 1'b1, 4'h5, 20'h1_20_77, 20'h33123, 8'h10, 4, "R7 in flight");
    req_valid = 1'b0;
    @(negedge clk);
    access(16'h5123, 1'b0, 4'h0, 20'h0, 20'h77123, 8'h20, 1, "R7 next access");
    req_valid = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule